// File: doc/BRIEF.md
# Latched Channel Selector with Dead-Time Sequencing

This block is the digital control for a bank of analog switches that connects one of several inputs to a shared output. A binary channel address and an enable enter a hold stage. That stage follows its inputs while an active-low write strobe is low. It freezes them once the strobe returns high. The held selection is decoded into a switch-drive vector with at most one active selection. An active-low reset empties the hold stage, so every switch opens.

Every move from one closed switch to a different one passes through an all-open interval before the new switch closes. The interval lasts `DEAD_CYCLES` system clock cycles. This keeps two inputs from ever being shorted together. Opening a switch, and closing one when all are open, take effect without that interval.

The strobe and the reset are brought into the clock domain through two flip-flops each. Reset asserts asynchronously and releases synchronously.

The selector is a three-state machine:

- **OFF**: all switches open.
- **ON**: one selection driven.
- **GAP**: the dead-time, counted down, all switches open.

The transitions are:

- **OFF→ON**: the target becomes non-empty.
- **ON→OFF** and **GAP→OFF**: the target becomes empty.
- **ON→GAP**: the target changes to a different channel.
- **GAP→ON**: the count expires.
- **GAP→GAP**: the count is still running. The newest target is tracked.

With `DIFF=0`, a 3-bit address picks one of 8 outputs. With `DIFF=1`, a 2-bit address picks one of 4 output pairs, and both bits of the chosen pair are driven together.

Top module: `chansel_bbm`

## Requirements
- R1: With DIFF=0 and enable held at 1, address value a drives output bit a only. Address 0 drives bit 0, and address 7 drives bit 7.
- R2: With DIFF=1 and enable held at 1, address value a drives bits 2a and 2a+1 together, and no other bit.
- R3: While the strobe is low, a change on address or enable appears at the outputs after the second rising clock edge following it.
- R4: A strobe falling edge makes the current address and enable visible after the fourth clock edge. Once the strobe has risen and the inputs are held stable for four further edges, later changes to address or enable have no effect on the outputs until the strobe goes low again.
- R5: Reset low clears the outputs at once, with no clock needed, and empties the hold stage. This holds even while the strobe is low. After release with the strobe high, the outputs stay all-zero. After release with the strobe low, the input selection appears after the sixth edge.
- R6: Enable 0 opens all switches after the second edge, whatever the address. No dead-time is inserted, and busy stays low.
- R7: A change from one active selection to a different one gives an all-zero output for exactly DEAD_CYCLES cycles, starting after the second edge. The new selection follows immediately after those cycles.
- R8: Moving from all-zero to an active selection inserts no gap.
- R9: busy is high exactly during the dead-time cycles and low at all other times.
- R10: At no cycle is more than one channel (one pair with DIFF=1) active. With DIFF=1, the two bits of each pair are always equal.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low reset; clears the hold stage and opens all switches |
| wr_ni | input | 1 | Active-low write strobe; hold stage transparent while low |
| addr_i | input | ADDR_W (3, or 2 with DIFF=1) | Binary channel address |
| en_i | input | 1 | Channel enable; 0 opens all switches |
| sel_o | output | OUT_W (8) | Switch-drive vector, at most one channel or pair active |
| busy_o | output | 1 | High while a dead-time gap is in progress |

## Verification
The bench steps through a channel change and checks every cycle of the gap. A design that closes the new switch early shows a non-zero vector or a short gap. One that lets the old switch linger shows two bits at once. A change that keeps the same pair in differential mode must not open a gap, while the single-ended output must sequence.

Changes made after the strobe rises must leave the outputs untouched. A hold stage that stays transparent would follow them.

Reset is applied with the strobe both high and low. A design that does not clear the held value would reselect the old channel after release. A design that lets the strobe override reset would keep a switch closed.

Disabling and first selection are timed to the edge. A design that inserts a gap on either would show a late output.

// File: rtl/chansel_pkg.sv
package chansel_pkg;

    typedef enum logic [1:0] {
        ST_OFF = 2'd0,
        ST_ON  = 2'd1,
        ST_GAP = 2'd2
    } sel_state_e;

endpackage

// File: rtl/chansel_sync.sv
module chansel_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk_i,
    input  logic arst_ni,
    input  logic d_i,
    output logic q_o
);

    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk_i or negedge arst_ni) begin
        if (!arst_ni) begin
            chain_q <= {STAGES{RST_VAL}};
        end else begin
            chain_q <= {chain_q[STAGES-2:0], d_i};
        end
    end

    assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/chansel_hold.sv
module chansel_hold #(
    parameter int ADDR_W = 3
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              wr_s_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              en_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic              en_o
);

    logic wr_q;
    logic cap_q;
    logic rise;

    assign rise = wr_s_i & ~wr_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            wr_q   <= 1'b1;
            cap_q  <= 1'b0;
            addr_o <= '0;
            en_o   <= 1'b0;
        end else begin
            wr_q  <= wr_s_i;
            cap_q <= rise;
            if (!wr_s_i || cap_q) begin
                addr_o <= addr_i;
                en_o   <= en_i;
            end
        end
    end

    // R4: while the strobe is high and no capture is pending, the held value is frozen
    assert_hold_stable_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_s_i && !cap_q) |=> ($stable(addr_o) && $stable(en_o)));

    // R5: reset leaves nothing enabled in the hold stage
    assert_clear_R5: assert property (@(posedge clk_i)
        !rst_ni |-> !en_o);

endmodule

// File: rtl/chansel_decode.sv
module chansel_decode #(
    parameter int ADDR_W = 3,
    parameter int NSEL   = 8
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              en_i,
    output logic [NSEL-1:0]   vec_o
);

    for (genvar g = 0; g < NSEL; g++) begin : g_chan
        assign vec_o[g] = en_i && (addr_i == ADDR_W'(g));
    end

endmodule

// File: rtl/chansel_seq.sv
module chansel_seq
    import chansel_pkg::*;
#(
    parameter  int NSEL        = 8,
    parameter  int DEAD_CYCLES = 3,
    localparam int CNT_W       = (DEAD_CYCLES > 1) ? $clog2(DEAD_CYCLES) : 1
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic [NSEL-1:0] tgt_i,
    output logic [NSEL-1:0] out_o,
    output logic            busy_o
);

    sel_state_e      st_q, st_d;
    logic [NSEL-1:0] cur_q, cur_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    // next state
    always_comb begin
        st_d  = st_q;
        cur_d = cur_q;
        cnt_d = cnt_q;
        unique case (st_q)
            ST_OFF: begin
                if (|tgt_i) begin
                    cur_d = tgt_i;
                    st_d  = ST_ON;
                end
            end
            ST_ON: begin
                if (!(|tgt_i)) begin
                    st_d = ST_OFF;
                end else if (tgt_i != cur_q) begin
                    st_d  = ST_GAP;
                    cur_d = tgt_i;
                    cnt_d = CNT_W'(DEAD_CYCLES - 1);
                end
            end
            ST_GAP: begin
                if (!(|tgt_i)) begin
                    st_d = ST_OFF;
                end else begin
                    cur_d = tgt_i;
                    if (cnt_q == '0) begin
                        st_d = ST_ON;
                    end else begin
                        cnt_d = cnt_q - 1'b1;
                    end
                end
            end
            default: st_d = ST_OFF;
        endcase
    end

    // state register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q  <= ST_OFF;
            cur_q <= '0;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cur_q <= cur_d;
            cnt_q <= cnt_d;
        end
    end

    // outputs
    always_comb begin
        out_o  = (st_q == ST_ON) ? cur_q : '0;
        busy_o = (st_q == ST_GAP);
    end

    // R7: an active selection never moves straight to another one
    assert_bbm_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (|out_o) |=> ((out_o == '0) || (out_o == $past(out_o))));

    // R9: a different non-empty target while driving starts a gap
    assert_gap_entry_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((st_q == ST_ON) && (|tgt_i) && (tgt_i != cur_q)) |=> busy_o);

    // R6: an empty target opens everything on the next cycle
    assert_off_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (tgt_i == '0) |=> ((out_o == '0) && !busy_o));

    // R8: from all-open, a target closes directly
    assert_direct_on_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((st_q == ST_OFF) && (|tgt_i)) |=> (out_o == $past(tgt_i)));

endmodule

// File: rtl/chansel_bbm.sv
module chansel_bbm #(
    parameter  int DIFF        = 0,
    parameter  int DEAD_CYCLES = 3,
    parameter  int SE_ADDR_W   = 3,
    parameter  int SYNC_STAGES = 2,
    localparam int ADDR_W      = (DIFF != 0) ? SE_ADDR_W - 1 : SE_ADDR_W,
    localparam int NSEL        = 1 << ADDR_W,
    localparam int OUT_W       = (DIFF != 0) ? 2 * NSEL : NSEL
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              wr_ni,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              en_i,
    output logic [OUT_W-1:0]  sel_o,
    output logic              busy_o
);

    logic              rst_s;
    logic              wr_s;
    logic [ADDR_W-1:0] held_addr;
    logic              held_en;
    logic [NSEL-1:0]   tgt;
    logic [NSEL-1:0]   ch_out;

    chansel_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_rst_sync (
        .clk_i   (clk_i),
        .arst_ni (rst_ni),
        .d_i     (1'b1),
        .q_o     (rst_s)
    );

    chansel_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_wr_sync (
        .clk_i   (clk_i),
        .arst_ni (rst_s),
        .d_i     (wr_ni),
        .q_o     (wr_s)
    );

    chansel_hold #(.ADDR_W(ADDR_W)) u_hold (
        .clk_i  (clk_i),
        .rst_ni (rst_s),
        .wr_s_i (wr_s),
        .addr_i (addr_i),
        .en_i   (en_i),
        .addr_o (held_addr),
        .en_o   (held_en)
    );

    chansel_decode #(.ADDR_W(ADDR_W), .NSEL(NSEL)) u_decode (
        .addr_i (held_addr),
        .en_i   (held_en),
        .vec_o  (tgt)
    );

    chansel_seq #(.NSEL(NSEL), .DEAD_CYCLES(DEAD_CYCLES)) u_seq (
        .clk_i  (clk_i),
        .rst_ni (rst_s),
        .tgt_i  (tgt),
        .out_o  (ch_out),
        .busy_o (busy_o)
    );

    if (DIFF != 0) begin : g_pairs
        for (genvar k = 0; k < NSEL; k++) begin : g_pair
            assign sel_o[2*k+1:2*k] = {2{ch_out[k]}};
        end
    end else begin : g_single
        assign sel_o = ch_out;
    end

    // R10: the sequencer never drives more than one channel
    assert_single_R10: assert property (@(posedge clk_i) disable iff (!rst_s)
        $onehot0(ch_out));

endmodule

// File: tb/chansel_bbm_bench.sv
module chansel_bbm_bench;

    localparam int DEAD = 3;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       wr_n;
    logic       en;
    logic [2:0] addr;
    logic [7:0] sel_se, sel_df;
    logic       busy_se, busy_df;

    always #5 clk = ~clk;

    chansel_bbm #(.DIFF(0), .DEAD_CYCLES(DEAD)) u_chansel_bbm (
        .clk_i(clk), .rst_ni(rst_n), .wr_ni(wr_n), .addr_i(addr), .en_i(en),
        .sel_o(sel_se), .busy_o(busy_se)
    );

    chansel_bbm #(.DIFF(1), .DEAD_CYCLES(DEAD)) u_chansel_bbm_diff (
        .clk_i(clk), .rst_ni(rst_n), .wr_ni(wr_n), .addr_i(addr[1:0]), .en_i(en),
        .sel_o(sel_df), .busy_o(busy_df)
    );

    typedef struct {
        int         cyc;
        int         mode;
        logic [7:0] v;
        logic       b;
        string      tag;
    } exp_t;

    exp_t       sb[$];
    int         cyc    = 0;
    int         checks = 0;
    int         errors = 0;
    logic [7:0] cur[2];

    function automatic logic [7:0] want(int m, logic [2:0] a, logic e);
        if (!e) return 8'h00;
        if (m == 0) return 8'h01 << a;
        return 8'h03 << (2 * a[1:0]);
    endfunction

    task automatic push(int c, int m, logic [7:0] v, logic b, string tag);
        exp_t x;
        x.cyc = c; x.mode = m; x.v = v; x.b = b; x.tag = tag;
        sb.push_back(x);
    endtask

    task automatic plan(int m, logic [7:0] nv, int base, string tag);
        logic [7:0] ov = cur[m];
        if (nv == ov || nv == 8'h00 || ov == 8'h00) begin
            push(base, m, nv, 1'b0, tag);
        end else begin
            for (int i = 0; i < DEAD; i++) push(base + i, m, 8'h00, 1'b1, tag);
            push(base + DEAD, m, nv, 1'b0, tag);
        end
        push(base + DEAD + 1, m, nv, 1'b0, tag);
        cur[m] = nv;
    endtask

    // driver: apply inputs, queue the expected response
    task automatic apply(logic [2:0] a, logic e, logic w, int lat, bit ignored, string tag);
        @(negedge clk);
        addr = a; en = e; wr_n = w;
        for (int m = 0; m < 2; m++)
            plan(m, ignored ? cur[m] : want(m, a, e), cyc + lat, tag);
        repeat (lat + DEAD + 3) @(negedge clk);
    endtask

    task automatic do_reset(string tag);
        @(negedge clk);
        rst_n = 1'b0;
        for (int m = 0; m < 2; m++) begin
            push(cyc + 1, m, 8'h00, 1'b0, tag);
            push(cyc + 3, m, 8'h00, 1'b0, tag);
            cur[m] = 8'h00;
        end
        repeat (4) @(negedge clk);
    endtask

    task automatic do_release(string tag);
        logic [7:0] nv;
        @(negedge clk);
        rst_n = 1'b1;
        for (int m = 0; m < 2; m++) begin
            nv = (!wr_n) ? want(m, addr, en) : 8'h00;
            push(cyc + 5, m, 8'h00, 1'b0, tag);
            push(cyc + 6, m, nv, 1'b0, tag);
            push(cyc + 8, m, nv, 1'b0, tag);
            cur[m] = nv;
        end
        repeat (10) @(negedge clk);
    endtask

    // monitor: per-cycle invariant plus scoreboard compare
    initial begin
        logic [7:0] s;
        logic       bb;
        forever begin
            @(posedge clk);
            cyc++;
            #2;
            checks++;
            if (!$onehot0(sel_se) || !$onehot0({sel_df[6], sel_df[4], sel_df[2], sel_df[0]}) ||
                ({sel_df[7], sel_df[5], sel_df[3], sel_df[1]} !== {sel_df[6], sel_df[4], sel_df[2], sel_df[0]})) begin
                errors++;
                $display("FAIL R10 cyc %0d: se %b df %b, expected at most one selection", cyc, sel_se, sel_df);
            end
            for (int i = sb.size() - 1; i >= 0; i--) begin
                if (sb[i].cyc == cyc) begin
                    s  = (sb[i].mode != 0) ? sel_df : sel_se;
                    bb = (sb[i].mode != 0) ? busy_df : busy_se;
                    checks++;
                    if (s !== sb[i].v || bb !== sb[i].b) begin
                        errors++;
                        $display("FAIL %s mode %0d cyc %0d: sel %b busy %b, expected sel %b busy %b",
                                 sb[i].tag, sb[i].mode, cyc, s, bb, sb[i].v, sb[i].b);
                    end
                    sb.delete(i);
                end
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not end, expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        cur[0] = 8'h00; cur[1] = 8'h00;
        rst_n = 1'b0; wr_n = 1'b1; en = 1'b0; addr = 3'd0;
        repeat (3) @(negedge clk);
        for (int m = 0; m < 2; m++) push(cyc + 1, m, 8'h00, 1'b0, "R5 reset state");
        addr = 3'd5; en = 1'b1;
        repeat (2) @(negedge clk);
        do_release("R5 release strobe high stays off");
        apply(3'd5, 1'b1, 1'b0, 4, 1'b0, "R4 R8 R1 R2 strobe fall");
        apply(3'd2, 1'b1, 1'b0, 2, 1'b0, "R3 R7 R9 change");
        apply(3'd6, 1'b1, 1'b0, 2, 1'b0, "R7 R2 same pair no gap");
        apply(3'd6, 1'b0, 1'b0, 2, 1'b0, "R6 disable");
        apply(3'd0, 1'b1, 1'b0, 2, 1'b0, "R8 R1 first select");
        apply(3'd7, 1'b1, 1'b0, 2, 1'b0, "R1 R2 R7 top channel");
        apply(3'd7, 1'b1, 1'b1, 4, 1'b1, "R4 strobe rise holds");
        apply(3'd3, 1'b1, 1'b1, 2, 1'b1, "R4 address ignored");
        apply(3'd3, 1'b0, 1'b1, 2, 1'b1, "R4 enable ignored");
        do_reset("R5 reset with strobe high");
        do_release("R5 latch cleared");
        apply(3'd4, 1'b1, 1'b0, 4, 1'b0, "R4 R8 strobe fall after reset");
        do_reset("R5 reset overrides strobe low");
        do_release("R5 resume after release");
        apply(3'd1, 1'b1, 1'b0, 2, 1'b0, "R7 R9 R3 second change");
        repeat (5) @(negedge clk);
        foreach (sb[i]) begin
            errors++;
            $display("FAIL %s: expectation at cyc %0d never sampled, expected %b", sb[i].tag, sb[i].cyc, sb[i].v);
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule